// File: doc/BRIEF.md
# Grouped Change-of-State Interrupt Unit

This unit watches 24 isolated input lines and 8 bidirectional lines and flags changes of state to software through a single interrupt wire. A byte-wide register port gives access to 24 output latches, the synchronized input levels, an edge-enable byte and four per-bit status bytes. Each group of eight monitored lines can be armed on its own for rising edges, falling edges or both. A matching edge sets a sticky status bit.

Software reads a status byte to learn which lines changed. It then writes that same byte back to the same offset, which clears exactly the bits that were 1 and leaves the others alone. The interrupt output stays high as long as any status bit is set.

The bidirectional lines get their output value and their drive enables from a dedicated side port. The status offset of the bidirectional group is used only to clear status, so it cannot carry that data.

Top module: `cos_irq_unit`

## Requirements
- R1: After reset, the output latches, the bidirectional output value, the drive enables, the edge-enable byte and every status bit are 0, and `irq` is low.
- R2: A bus write to offsets 0, 1 or 2 loads bits 7:0, 15:8 or 23:16 of `fet_out` at the next clock edge, and a read of the same offset returns that byte.
- R3: Offsets 4, 5 and 6 read bytes 0, 1 and 2 of `iso_in`, and offset 7 reads `gp_in`. Each value is taken after two synchronizing flops, so a pin change shows in `rdata` after the second clock edge that follows it.
- R4: Offset 14 holds the edge-enable byte and reads it back. Bits 0, 1 and 2 arm rising edges for input lines 0-7, 8-15 and 16-23, and bit 3 arms rising edges for the bidirectional lines. Bits 4 to 7 arm falling edges for the same four groups in the same order.
- R5: A status bit is set at the third clock edge after its pin changes, and only if that edge's polarity is armed for the line's group. An edge whose polarity is not armed leaves status unchanged.
- R6: Offsets 8, 9 and 10 read the status of input lines 0-7, 8-15 and 16-23, and offset 11 reads the status of the bidirectional lines.
- R7: A bus write to offsets 8 to 11 clears the status bits of that byte where the written data has a 1. Bits where the data has a 0 keep their value.
- R8: If a new armed edge and a clear hit the same status bit at the same clock edge, the bit ends up set.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: A pulse on `gp_wr` loads `gp_out` from `gp_wdata` and `gp_oe` from `gp_wdir`. Bus writes to offsets 7 and 11 leave both unchanged.
- R11: Offsets 3, 12, 13 and 15 read as 0. Bus writes to offsets 4 to 7 and to the unmapped offsets change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| iso_in | input | 24 | Isolated input lines |
| fet_out | output | 24 | Output latch lines |
| gp_in | input | 8 | Pin levels of the bidirectional lines |
| gp_out | output | 8 | Output value for the bidirectional lines |
| gp_oe | output | 8 | Drive enable per bidirectional line, 1 = drive |
| gp_wr | input | 1 | Side-port write strobe |
| gp_wdata | input | 8 | Side-port output value |
| gp_wdir | input | 8 | Side-port drive enables |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The assertions assume that `wr_en` and `gp_wr` are single-cycle strobes and that `addr` and `wdata` hold steady around the clock edge. They also assume that pin inputs change only between edges, so that every edge the synchronizer sees is one clean transition. The stimulus drives every input on the falling clock edge and never toggles a line more than once per cycle. It sets up the same-edge clear case by writing the clear in exactly the cycle in which a new edge reaches the status logic.

// File: rtl/cos_irq_unit.sv
module cos_irq_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [23:0] iso_in,
  output logic [23:0] fet_out,
  input  logic [7:0]  gp_in,
  output logic [7:0]  gp_out,
  output logic [7:0]  gp_oe,
  input  logic        gp_wr,
  input  logic [7:0]  gp_wdata,
  input  logic [7:0]  gp_wdir,
  output logic        irq
);

  localparam int NGRP = 4;
  localparam int NLINE = NGRP * 8;

  logic [NLINE-1:0] sync1, sync2, prev, status;
  logic [NLINE-1:0] rise, fall, hit, clr;
  logic [7:0]       en_reg;

  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign hit[g*8 +: 8] = (rise[g*8 +: 8] & {8{en_reg[g]}})
                         | (fall[g*8 +: 8] & {8{en_reg[g+NGRP]}});
    assign clr[g*8 +: 8] = (wr_en && addr == 4'(8 + g)) ? wdata : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      status <= '0;
    end else begin
      sync1  <= {gp_in, iso_in};
      sync2  <= sync1;
      prev   <= sync2;
      status <= (status & ~clr) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fet_out <= '0;
      en_reg  <= '0;
    end else if (wr_en) begin
      case (addr)
        4'd0:  fet_out[7:0]   <= wdata;
        4'd1:  fet_out[15:8]  <= wdata;
        4'd2:  fet_out[23:16] <= wdata;
        4'd14: en_reg         <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_out <= '0;
      gp_oe  <= '0;
    end else if (gp_wr) begin
      gp_out <= gp_wdata;
      gp_oe  <= gp_wdir;
    end
  end

  always_comb begin
    case (addr)
      4'd0:  rdata = fet_out[7:0];
      4'd1:  rdata = fet_out[15:8];
      4'd2:  rdata = fet_out[23:16];
      4'd4:  rdata = sync2[7:0];
      4'd5:  rdata = sync2[15:8];
      4'd6:  rdata = sync2[23:16];
      4'd7:  rdata = sync2[31:24];
      4'd8:  rdata = status[7:0];
      4'd9:  rdata = status[15:8];
      4'd10: rdata = status[23:16];
      4'd11: rdata = status[31:24];
      4'd14: rdata = en_reg;
      default: rdata = 8'h00;
    endcase
  end

  assign irq = |status;

endmodule

module cos_irq_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  addr,
  input logic        wr_en,
  input logic        gp_wr,
  input logic [23:0] fet_out,
  input logic [7:0]  gp_out,
  input logic [7:0]  gp_oe,
  input logic        irq,
  input logic [31:0] status,
  input logic [7:0]  en_reg
);

  // R5
  no_set_when_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_reg == 8'h00) |=> ((status & ~$past(status)) == 32'h0));

  // R7
  hold_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr >= 4'd8 && addr <= 4'd11) |=> ((status & $past(status)) == $past(status)));

  // R9
  irq_needs_arming_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(en_reg) != 8'h00));

  // R10
  side_port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gp_wr |=> ($stable(gp_out) && $stable(gp_oe)));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr <= 4'd2) |=> $stable(fet_out));

endmodule

bind cos_irq_unit cos_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .gp_wr(gp_wr),
  .fet_out(fet_out), .gp_out(gp_out), .gp_oe(gp_oe), .irq(irq),
  .status(status), .en_reg(en_reg)
);

// File: tb/cos_irq_unit_test.sv
module cos_irq_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = 0;
  logic        wr_en = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [23:0] iso_in = 0;
  logic [23:0] fet_out;
  logic [7:0]  gp_in = 0;
  logic [7:0]  gp_out, gp_oe;
  logic        gp_wr = 0;
  logic [7:0]  gp_wdata = 0, gp_wdir = 0;
  logic        irq;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  cos_irq_unit uut (.*);

  always #5 clk = ~clk;

  // behavioural reference model
  logic [31:0] hist[$];
  logic [31:0] m_st;
  logic [23:0] m_fet;
  logic [7:0]  m_en, m_gpo, m_gpoe;

  initial begin
    hist = '{32'h0, 32'h0, 32'h0};
    m_st = 0; m_fet = 0; m_en = 0; m_gpo = 0; m_gpoe = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0, 32'h0};
      m_st = 0; m_fet = 0; m_en = 0; m_gpo = 0; m_gpoe = 0;
    end else begin
      logic [31:0] h, c;
      h = 0;
      for (int i = 0; i < 32; i++) begin
        int g;
        g = i / 8;
        if ((hist[1][i] && !hist[2][i] && m_en[g]) || (!hist[1][i] && hist[2][i] && m_en[g+4]))
          h[i] = 1'b1;
      end
      c = 0;
      if (wr_en && addr >= 8 && addr <= 11) c = {24'h0, wdata} << (8 * (int'(addr) - 8));
      if (wr_en) begin
        if (addr <= 2) m_fet[8*addr +: 8] = wdata;
        if (addr == 14) m_en = wdata;
      end
      if (gp_wr) begin m_gpo = gp_wdata; m_gpoe = gp_wdir; end
      m_st = (m_st & ~c) | h;
      void'(hist.pop_back());
      hist.push_front({gp_in, iso_in});
    end
  end

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a <= 2) return m_fet[8*a +: 8];
    if (a >= 4 && a <= 7) return hist[1][8*(a-4) +: 8];
    if (a >= 8 && a <= 11) return m_st[8*(a-8) +: 8];
    if (a == 14) return m_en;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rd_req(input logic [3:0] a);
    if (a <= 2) return "R2";
    if (a >= 4 && a <= 7) return "R3";
    if (a >= 8 && a <= 11) return "R6";
    if (a == 14) return "R4";
    return "R11";
  endfunction

  always @(posedge clk) begin
    #3;
    if (cmp_on) begin
      check("R9 irq", {31'h0, irq}, {31'h0, m_st != 0});
      check("R2 fet_out", {8'h0, fet_out}, {8'h0, m_fet});
      check("R10 gp_out", {24'h0, gp_out}, {24'h0, m_gpo});
      check("R10 gp_oe", {24'h0, gp_oe}, {24'h0, m_gpoe});
      check(rd_req(addr), {24'h0, rdata}, {24'h0, m_read(addr)});
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    @(posedge clk); #3;
    d = rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    check("R1 fet_out", {8'h0, fet_out}, 32'h0);
    check("R1 gp_oe", {24'h0, gp_oe}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 8; a <= 14; a++) begin
      peek(4'(a), v);
      if (a <= 11 || a == 14) check("R1 regs", {24'h0, v}, 32'h0);
    end
    // R2 output latches
    bus_wr(0, 8'hA5); bus_wr(1, 8'h3C); bus_wr(2, 8'hF0);
    check("R2 latch", {8'h0, fet_out}, 32'hF03CA5);
    for (int a = 0; a < 3; a++) peek(4'(a), v);
    // R5 edges with nothing armed
    iso_in = 24'h00FF0F; gp_in = 8'h81;
    idle(4);
    check("R5 disarmed", {31'h0, irq}, 32'h0);
    for (int a = 4; a <= 7; a++) peek(4'(a), v);
    // R3 two-edge visibility
    addr = 4; iso_in[7:0] = 8'h55;
    @(posedge clk); #3; check("R3 one edge", {24'h0, rdata}, 32'h0F);
    @(posedge clk); #3; check("R3 two edges", {24'h0, rdata}, 32'h55);
    @(negedge clk);
    // R4 arm rising grp0, falling grp1
    bus_wr(14, 8'h21);
    peek(14, v); check("R4 enable readback", {24'h0, v}, 32'h21);
    iso_in = 24'h0000FF;
    idle(4);
    peek(8, v); check("R5 rising grp0", {24'h0, v}, 32'hAA);
    peek(9, v); check("R5 falling grp1", {24'h0, v}, 32'hFF);
    // bidir group both polarities
    bus_wr(14, 8'h88);
    gp_in = 8'h18;
    idle(4);
    peek(11, v); check("R6 bidir status", {24'h0, v}, 32'h99);
    // R7 selective clear
    bus_wr(9, 8'h0F);
    peek(9, v); check("R7 partial clear", {24'h0, v}, 32'hF0);
    bus_wr(11, 8'h99);
    peek(11, v); check("R7 full clear", {24'h0, v}, 32'h00);
    // R8 set wins over clear
    gp_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_wr(11, 8'h01);
    peek(11, v); check("R8 set beats clear", {24'h0, v & 8'h01}, 32'h01);
    // R10 side port and bus writes to 7/11
    gp_wr = 1; gp_wdata = 8'hC3; gp_wdir = 8'h0F;
    @(negedge clk); gp_wr = 0;
    bus_wr(7, 8'hFF); bus_wr(11, 8'h00);
    check("R10 side port", {16'h0, gp_out, gp_oe}, 32'hC30F);
    // R11 unmapped and read-only offsets
    bus_wr(4, 8'h12); bus_wr(13, 8'h34); bus_wr(15, 8'h56);
    foreach (v[i]) ;
    peek(3, v);  check("R11 off3", {24'h0, v}, 32'h0);
    peek(12, v); check("R11 off12", {24'h0, v}, 32'h0);
    peek(13, v); check("R11 off13", {24'h0, v}, 32'h0);
    peek(15, v); check("R11 off15", {24'h0, v}, 32'h0);
    // R9 clear everything
    bus_wr(14, 8'h00);
    bus_wr(8, 8'hFF); bus_wr(9, 8'hFF); bus_wr(10, 8'hFF); bus_wr(11, 8'hFF);
    idle(2);
    check("R9 irq low", {31'h0, irq}, 32'h0);
    finish_run();
  end
endmodule